// File: doc/BRIEF.md
# Edge-Detected Sample Pulse Generator

This block produces the internal video-sample timing pulse that downstream timing logic uses to start each sample. The pulse is taken from an external sample-clock input in one of two ways. In bypass mode the external level is passed through unchanged. In regenerate mode the external signal is first brought into the data-clock domain. The block then watches for one selected edge of it and, a programmable number of data-clock periods later, issues a clean pulse one data clock wide.

Regeneration lets the sampling instant be moved in whole data-clock steps relative to a sample clock whose phase is not controlled. It also removes any dependence on the width of the incoming pulse. Three inputs configure the block: a mode enable, an edge-polarity select and a three-bit delay. At reset all three are expected to be zero, which selects bypass, falling edge and no delay.

Top module: `sp_pulse_regen`

## Requirements
- R1: While `det_en` is 0, `smp_out` equals `smp_in` combinationally, whatever `edge_pol` and `dly_sel` hold, and no delayed pulse is left pending.
- R2: In regenerate mode `smp_in` passes through two data-clock flip-flops before edge detection. An input change made between rising edges P0 and P1 is detected in the cycle that follows rising edge P2.
- R3: `edge_pol` = 1 selects rising edges of `smp_in` and `edge_pol` = 0 selects falling edges. An edge of the other direction, or no level change at all, produces no pulse.
- R4: With `dly_sel` = N (0 to 7), the regenerated pulse appears N cycles after the detection cycle. N = 0 puts the pulse in the detection cycle itself.
- R5: Each regenerated pulse lasts exactly one data-clock cycle.
- R6: A selected edge detected while an earlier delayed pulse is still pending cancels that pulse, and the delay restarts from the new edge.
- R7: An active-low reset clears the synchronizer, the edge history and any pending pulse, so that no pulse follows the release of reset while `smp_in` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_in | input | 1 | External sample-clock signal |
| det_en | input | 1 | 1 selects regenerate mode, 0 selects bypass |
| edge_pol | input | 1 | 1 selects rising edges, 0 selects falling edges |
| dly_sel | input | 3 | Delay from detection to pulse, in data-clock periods |
| smp_out | output | 1 | Internal sample pulse |

## Verification
The bench works out the exact cycle of every pulse, so a synchronizer with one flip-flop too many or too few, or a delay counter off by one, moves the pulse and is caught. It runs each polarity setting against the opposite edge and against an unchanged level, which exposes an inverted polarity select or a detector that fires on both directions. A retriggered edge during a pending delay checks that the old pulse never appears, since a design that queued or ignored the second edge would pulse at the first deadline. A reset taken mid-delay checks that a stale count is not released afterwards.

// File: rtl/sp_pkg.sv
package sp_pkg;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

endpackage

// File: rtl/sp_sync.sv
module sp_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.chain[STAGES-1];

endmodule

// File: rtl/sp_edge.sv
module sp_edge
    import sp_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      lvl,
    input  edge_sel_e sel,
    output logic      hit
);

    typedef struct packed {
        logic prev;
    } edge_st_t;

    edge_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.prev = lvl;
        if (sel == EDGE_RISE) begin
            hit = lvl & ~st_q.prev;
        end else begin
            hit = ~lvl & st_q.prev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_NO_EDGE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R5

endmodule

// File: rtl/sp_timer.sv
module sp_timer #(
    parameter int DLY_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hit,
    input  logic [DLY_W-1:0] dly,
    output logic             fire
);

    localparam logic [DLY_W-1:0] CNT_ONE  = DLY_W'(1);
    localparam logic [DLY_W-1:0] CNT_ZERO = '0;

    typedef struct packed {
        logic [DLY_W-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (clr) begin
            st_d.cnt = CNT_ZERO;
        end else if (hit) begin
            fire     = (dly == CNT_ZERO);
            st_d.cnt = dly;
        end else if (st_q.cnt != CNT_ZERO) begin
            fire     = (st_q.cnt == CNT_ONE);
            st_d.cnt = st_q.cnt - CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !hit && st_q.cnt != CNT_ZERO) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE)); // R4

    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && hit) |=> (st_q.cnt == $past(dly))); // R6

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == CNT_ZERO)); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == CNT_ZERO && !hit) |-> !fire); // R5

endmodule

// File: rtl/sp_pulse_regen.sv
module sp_pulse_regen
    import sp_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_W       = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_in,
    input  logic             det_en,
    input  logic             edge_pol,
    input  logic [DLY_W-1:0] dly_sel,
    output logic             smp_out
);

    logic      lvl_sync;
    logic      edge_hit;
    logic      tmr_fire;
    edge_sel_e edge_sel;

    assign edge_sel = edge_sel_e'(edge_pol);

    sp_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (smp_in),
        .q     (lvl_sync)
    );

    sp_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (lvl_sync),
        .sel   (edge_sel),
        .hit   (edge_hit)
    );

    sp_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!det_en),
        .hit   (edge_hit),
        .dly   (dly_sel),
        .fire  (tmr_fire)
    );

    always_comb begin
        if (det_en) begin
            smp_out = tmr_fire;
        end else begin
            smp_out = smp_in;
        end
    end

    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !det_en |-> (smp_out == smp_in)); // R1

endmodule

// File: tb/sp_pulse_regen_test.sv
`timescale 1ns/1ps
module sp_pulse_regen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       smp_in = 1'b0;
    logic       det_en = 1'b0;
    logic       edge_pol = 1'b0;
    logic [2:0] dly_sel = 3'd0;
    logic       smp_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sp_pulse_regen uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_in   (smp_in),
        .det_en   (det_en),
        .edge_pol (edge_pol),
        .dly_sel  (dly_sel),
        .smp_out  (smp_out)
    );

    // vector fields: {pol, dly[2:0], from_level, to_level}
    localparam int NVEC = 12;
    localparam logic [5:0] VEC [NVEC] = '{
        {1'b1, 3'd0, 1'b0, 1'b1},
        {1'b1, 3'd3, 1'b0, 1'b1},
        {1'b1, 3'd7, 1'b0, 1'b1},
        {1'b0, 3'd0, 1'b1, 1'b0},
        {1'b0, 3'd5, 1'b1, 1'b0},
        {1'b0, 3'd1, 1'b1, 1'b0},
        {1'b1, 3'd2, 1'b1, 1'b0},
        {1'b0, 3'd4, 1'b0, 1'b1},
        {1'b1, 3'd6, 1'b1, 1'b1},
        {1'b0, 3'd2, 1'b0, 1'b0},
        {1'b1, 3'd1, 1'b0, 1'b1},
        {1'b0, 3'd7, 1'b1, 1'b0}
    };

    task automatic check(input logic act, input logic exp, input string req, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R7: reset state, bypass with all fields zero
        repeat (3) @(negedge clk);
        check(smp_out, 1'b0, "R7", "output in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(smp_out, 1'b0, "R7", "output after reset");

        // R1: bypass follows input combinationally, fields ignored
        smp_in = 1'b1; #1;
        check(smp_out, 1'b1, "R1", "bypass high");
        edge_pol = 1'b1; dly_sel = 3'd5; #1;
        check(smp_out, 1'b1, "R1", "bypass high with fields set");
        smp_in = 1'b0; #1;
        check(smp_out, 1'b0, "R1", "bypass low with fields set");
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(smp_out, 1'b0, "R1", "bypass stays low");
        end

        // Table walk: R2 R3 R4 R5
        for (int v = 0; v < NVEC; v++) begin
            logic       pol;
            logic [2:0] d;
            logic       from_l, to_l, match;
            {pol, d, from_l, to_l} = VEC[v];
            match = pol ? (!from_l && to_l) : (from_l && !to_l);
            @(negedge clk);
            det_en = 1'b1; edge_pol = pol; dly_sel = d; smp_in = from_l;
            repeat (12) @(negedge clk);
            smp_in = to_l;
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                check(smp_out, match && (k == 2 + int'(d)), "R2 R3 R4 R5", $sformatf("vector %0d cycle %0d", v, k));
            end
        end

        // R6: second rising edge restarts a delay of 4
        @(negedge clk);
        det_en = 1'b1; edge_pol = 1'b1; dly_sel = 3'd4; smp_in = 1'b0;
        repeat (12) @(negedge clk);
        smp_in = 1'b1;
        @(negedge clk);
        check(smp_out, 1'b0, "R6", "cycle 1");
        smp_in = 1'b0;
        @(negedge clk);
        check(smp_out, 1'b0, "R6", "cycle 2");
        smp_in = 1'b1;
        for (int k = 3; k <= 12; k++) begin
            @(negedge clk);
            check(smp_out, k == 8, "R6", $sformatf("restart cycle %0d", k));
        end

        // R1: leaving detect mode drops a pending pulse
        @(negedge clk);
        smp_in = 1'b0; dly_sel = 3'd6; edge_pol = 1'b0;
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        det_en = 1'b0; #1;
        check(smp_out, 1'b0, "R1", "bypass after pending");
        @(negedge clk);
        det_en = 1'b1;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            check(smp_out, 1'b0, "R1", $sformatf("dropped pulse cycle %0d", k));
        end

        // R7: reset mid-delay clears the pending pulse
        @(negedge clk);
        edge_pol = 1'b1; dly_sel = 3'd7; smp_in = 1'b0;
        repeat (12) @(negedge clk);
        smp_in = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b0; smp_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            check(smp_out, 1'b0, "R7", $sformatf("post-reset cycle %0d", k));
        end

        finish_run();
    end

endmodule